// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block decides which of eight memory banks a bus access belongs to. Software sets up each bank through a small register bus. Each bank has a base word and an option word. The base word holds the bank's base address, its address-space type, its port size, the parity switch, write protection, which timing machine runs it, and a valid flag. The option word holds the masks that choose which address bits and which type bits take part in the comparison.

On every access the decoder compares the upper 17 address bits and the 3-bit address type with each bank, in parallel. An access from an external master always carries type `3'b100`. The lowest-numbered valid bank that matches wins. The decoder raises that bank's chip select and the transfer acknowledge enable, all in the same cycle as the access. It also reports the winning bank's port size, parity enable and machine. A write that lands on a write-protected bank gets neither a chip select nor an acknowledge. Instead it sets a sticky error bit, and the access is left for an external bus monitor to end.

Top module: `bank_cs_decoder`

## Requirements
- R1: After reset, bank 0's valid bit and port size come from `cfg_bank0_valid` and `cfg_bank0_ps`. All its other fields are zero, banks 1 to 7 read back as all zero, and the write-protect error bit is 0.
- R2: Register map. `reg_addr` = {0, bank[2:0], 0} is the base word and {0, bank, 1} is the option word. `5'h10` is the status word, with bit 0 the write-protect error. Reads are combinational.
- R3: Base word fields are: base address [31:15], type [14:12], port size [11:10] (00 = 32-bit, 01 = 8-bit, 10 = 16-bit), parity enable [9], write protect [8], machine [7:6] (00 = general-purpose, 10 = machine A, 11 = machine B) and valid [0]. Option word fields are: address mask [31:15] and type mask [14:12]. Reserved bits read back as 0 and writes to them are ignored.
- R4: An address bit takes part in the match only where its address-mask bit is 1. A bit whose mask bit is 0 never prevents a hit.
- R5: Type bits take part only where the type-mask bit is 1. When `acc_ext` = 1 the access type is taken as `3'b100` and `acc_type` is ignored.
- R6: A bank whose valid bit is 0 never matches. An access that matches only invalid banks gives `hit` = 0, no chip select and no acknowledge.
- R7: When several valid banks match, the lowest-numbered bank wins and at most one `chip_sel` bit is ever high.
- R8: On a hit, `hit_bank`, `port_size`, `parity_en` and `machine` show the winning bank's fields. They all show 0 when there is no hit.
- R9: A write that hits a write-protected bank drives no chip select and no `xfer_ack`. It sets `wp_err` at the next clock edge. A read of the same bank is acknowledged with its chip select.
- R10: `wp_err` holds until a register write of 1 to status bit 0. Writing 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R11: While `acc_valid` = 0, no chip select and no acknowledge are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bank0_valid | input | 1 | Reset value of bank 0 valid bit |
| cfg_bank0_ps | input | 2 | Reset value of bank 0 port size |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Bus access present |
| acc_write | input | 1 | Access is a write |
| acc_ext | input | 1 | Access comes from an external master |
| acc_addr_hi | input | 17 | Upper 17 bits of the access address |
| acc_type | input | 3 | Address-space type from the bus |
| hit | output | 1 | A valid bank matches |
| hit_bank | output | 3 | Number of the winning bank |
| chip_sel | output | 8 | One chip select per bank, active high |
| xfer_ack | output | 1 | Transfer acknowledge enable |
| port_size | output | 2 | Winning bank's port size |
| parity_en | output | 1 | Winning bank's parity enable |
| machine | output | 2 | Winning bank's machine select |
| wp_err | output | 1 | Sticky write-protect error |

## Verification
The bench sets up two valid banks that overlap, so that a priority encoder that favours the higher bank, or that raises both selects, shows up at once. It covers a match that depends on a masked-off address bit and one that depends on the type mask. A decoder that compares unmasked bits would miss the first, and one that uses `acc_type` for external masters would mismatch the second. A write to a write-protected bank must drop both chip select and acknowledge while a read of the same bank still goes through. The sticky error bit is driven through idle cycles, a write of 0, a write-1 clear, and a clear in the same cycle as a new violation; a design that lets the clear win loses that error.

// File: rtl/bank_dec_pkg.sv
// Package: shared field types and register layout for the bank decoder.
// Assumes a 32-bit register word; field positions are fixed here.
package bank_dec_pkg;
    localparam int REG_W = 32;
    localparam int BA_W  = 17;
    localparam int AT_W  = 3;

    localparam logic [AT_W-1:0] EXT_TYPE = 3'b100;

    typedef struct packed {
        logic [BA_W-1:0] ba;   // base address bits
        logic [AT_W-1:0] at;   // address-space type
        logic [1:0]      ps;   // port size
        logic            pe;   // parity enable
        logic            wp;   // write protect
        logic [1:0]      ms;   // machine select
        logic            v;    // bank valid
    } base_t;

    typedef struct packed {
        logic [BA_W-1:0] am;   // address compare mask
        logic [AT_W-1:0] atm;  // type compare mask
    } opt_t;

    // Build the readable base word; reserved bits stay zero.
    function automatic logic [REG_W-1:0] pack_base(base_t b);
        return {b.ba, b.at, b.ps, b.pe, b.wp, b.ms, 5'b0, b.v};
    endfunction

    // Extract base fields from a written word.
    function automatic base_t unpack_base(logic [REG_W-1:0] w);
        base_t b;
        b.ba = w[31:15];
        b.at = w[14:12];
        b.ps = w[11:10];
        b.pe = w[9];
        b.wp = w[8];
        b.ms = w[7:6];
        b.v  = w[0];
        return b;
    endfunction

    function automatic logic [REG_W-1:0] pack_opt(opt_t o);
        return {o.am, o.atm, 12'b0};
    endfunction

    function automatic opt_t unpack_opt(logic [REG_W-1:0] w);
        opt_t o;
        o.am  = w[31:15];
        o.atm = w[14:12];
        return o;
    endfunction
endpackage

// File: rtl/bank_regs.sv
// Module: holds one bank's base and option fields.
// Assumes the write strobes are already decoded for this bank. Bank 0 takes its
// valid bit and port size from configuration pins at reset; others reset empty.
module bank_regs
    import bank_dec_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_base,
    input  logic             we_opt,
    input  logic [REG_W-1:0] wdata,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_ps,
    output base_t            base_q,
    output opt_t             opt_q
);
    localparam bit IS_BOOT = (BANK_IDX == 0);

    // Base fields: reset load, then register-bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            base_q.v  <= IS_BOOT ? cfg_valid : 1'b0;
            base_q.ps <= IS_BOOT ? cfg_ps : 2'b00;
        end else if (we_base) begin
            base_q <= unpack_base(wdata);
        end
    end

    // Option fields: cleared at reset, written by the register bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      opt_q <= '0;
        else if (we_opt) opt_q <= unpack_opt(wdata);
    end
endmodule

// File: rtl/bank_match.sv
// Module: compares one bank against the current access.
// Assumes the access type is already resolved for external masters.
module bank_match
    import bank_dec_pkg::*;
(
    input  base_t           base_i,
    input  opt_t            opt_i,
    input  logic [BA_W-1:0] addr_hi,
    input  logic [AT_W-1:0] atype,
    output logic            match
);
    logic addr_ok;
    logic type_ok;

    // Masked address and type equality, gated by the valid bit.
    always_comb begin
        addr_ok = ((addr_hi ^ base_i.ba) & opt_i.am) == '0;
        type_ok = ((atype ^ base_i.at) & opt_i.atm) == '0;
        match   = base_i.v & addr_ok & type_ok;
    end
endmodule

// File: rtl/bank_prio_sel.sv
// Module: fixed-priority pick of the lowest set bit of a match vector.
// Assumes N is at least 2.
module bank_prio_sel #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest matching index is the last one kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bank_cs_decoder.sv
// Module: top of the bank decoder. Register file, parallel match, priority
// pick, chip select, write-protect handling and the sticky error bit.
// Assumes the access inputs are stable in the cycle they are presented; all
// decode outputs are combinational, only wp_err is registered.
module bank_cs_decoder
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int IDX_W     = $clog2(NUM_BANKS),
    parameter int RA_W      = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bank0_valid,
    input  logic [1:0]       cfg_bank0_ps,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_ext,
    input  logic [BA_W-1:0]  acc_addr_hi,
    input  logic [AT_W-1:0]  acc_type,
    output logic             hit,
    output logic [IDX_W-1:0] hit_bank,
    output logic [NUM_BANKS-1:0] chip_sel,
    output logic             xfer_ack,
    output logic [1:0]       port_size,
    output logic             parity_en,
    output logic [1:0]       machine,
    output logic             wp_err
);
    localparam logic [RA_W-1:0] STAT_ADDR = RA_W'(1) << (RA_W - 1);

    base_t bank_base [NUM_BANKS];
    opt_t  bank_opt  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_hit;
    logic [AT_W-1:0]      eff_type;
    logic                 is_bank_reg;
    logic [IDX_W-1:0]     reg_bank;
    logic                 found;
    logic [IDX_W-1:0]     win;
    base_t                win_base;
    logic                 wp_block;
    logic                 wp_set;
    logic                 wp_clr;

    assign is_bank_reg = ~reg_addr[RA_W-1];
    assign reg_bank    = reg_addr[IDX_W:1];

    // External masters carry a fixed address type.
    assign eff_type = acc_ext ? EXT_TYPE : acc_type;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic we_b;
        logic we_o;
        assign we_b = reg_we & is_bank_reg & (reg_bank == IDX_W'(g)) & ~reg_addr[0];
        assign we_o = reg_we & is_bank_reg & (reg_bank == IDX_W'(g)) &  reg_addr[0];

        bank_regs #(.BANK_IDX(g)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_base   (we_b),
            .we_opt    (we_o),
            .wdata     (reg_wdata),
            .cfg_valid (cfg_bank0_valid),
            .cfg_ps    (cfg_bank0_ps),
            .base_q    (bank_base[g]),
            .opt_q     (bank_opt[g])
        );

        bank_match u_match (
            .base_i  (bank_base[g]),
            .opt_i   (bank_opt[g]),
            .addr_hi (acc_addr_hi),
            .atype   (eff_type),
            .match   (bank_hit[g])
        );
    end

    bank_prio_sel #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
        .req   (bank_hit),
        .found (found),
        .idx   (win)
    );

    // Decode outputs for the winning bank.
    always_comb begin
        win_base  = bank_base[win];
        hit       = acc_valid & found;
        wp_block  = hit & acc_write & win_base.wp;
        xfer_ack  = hit & ~wp_block;
        chip_sel  = '0;
        if (xfer_ack) chip_sel[win] = 1'b1;
        hit_bank  = hit ? win : '0;
        port_size = hit ? win_base.ps : 2'b00;
        parity_en = hit & win_base.pe;
        machine   = hit ? win_base.ms : 2'b00;
    end

    assign wp_set = wp_block;
    assign wp_clr = reg_we & (reg_addr == STAT_ADDR) & reg_wdata[0];

    // Sticky write-protect error; a new violation beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      wp_err <= 1'b0;
        else if (wp_set) wp_err <= 1'b1;
        else if (wp_clr) wp_err <= 1'b0;
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STAT_ADDR)
            reg_rdata = {{(REG_W-1){1'b0}}, wp_err};
        else if (is_bank_reg)
            reg_rdata = reg_addr[0] ? pack_opt(bank_opt[reg_bank])
                                    : pack_base(bank_base[reg_bank]);
    end
endmodule

// File: rtl/bank_cs_decoder_chk.sv
// Checker: temporal properties of the bank decoder's ports, bound to the top.
// Assumes the decoder's port names; attached with the bind at the end.
module bank_cs_decoder_chk #(
    parameter int NUM_BANKS = 8,
    parameter int RA_W      = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [RA_W-1:0]      reg_addr,
    input logic [31:0]          reg_wdata,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic                 hit,
    input logic [NUM_BANKS-1:0] chip_sel,
    input logic                 xfer_ack,
    input logic                 wp_err
);
    localparam logic [RA_W-1:0] STAT_ADDR = RA_W'(1) << (RA_W - 1);

    logic clr_req;
    assign clr_req = reg_we && (reg_addr == STAT_ADDR) && reg_wdata[0];

    assert_onehot_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (chip_sel == '0) && !xfer_ack);

    assert_cs_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel != '0) |-> hit);

    assert_ack_with_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> (chip_sel != '0));

    assert_wp_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit && !xfer_ack) |=> wp_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_err && !clr_req) |=> wp_err);
endmodule

bind bank_cs_decoder bank_cs_decoder_chk #(.NUM_BANKS(NUM_BANKS), .RA_W(RA_W)) u_chk (.*);

// File: tb/sim_bank_cs_decoder.sv
// Directed bench for bank_cs_decoder: one task per scenario.
module sim_bank_cs_decoder;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bank0_valid = 1'b1;
    logic [1:0]  cfg_bank0_ps = 2'b10;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_ext = 1'b0;
    logic [16:0] acc_addr_hi = '0;
    logic [2:0]  acc_type = '0;
    logic        hit;
    logic [2:0]  hit_bank;
    logic [7:0]  chip_sel;
    logic        xfer_ack;
    logic [1:0]  port_size;
    logic        parity_en;
    logic [1:0]  machine;
    logic        wp_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bank_cs_decoder u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [4:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    // Present an access, let outputs settle, leave it applied.
    task automatic access(logic w, logic ext, logic [31:0] addr, logic [2:0] t);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_ext = ext;
        acc_addr_hi = addr[31:15]; acc_type = t;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 wp_err", {31'b0, wp_err}, 32'h0);
        rd_check("R1 base0", 5'h00, 32'h0000_0801);
        rd_check("R1 opt0",  5'h01, 32'h0);
        rd_check("R1 base3", 5'h06, 32'h0);
        rd_check("R2 status", 5'h10, 32'h0);
        idle();
        check("R11 idle cs", {24'b0, chip_sel}, 32'h0);
        access(1'b0, 1'b0, 32'h7777_0000, 3'b011);
        check("R1 boot cs", {24'b0, chip_sel}, 32'h1);
        check("R8 boot ps", {30'b0, port_size}, 32'h2);
        idle();
    endtask

    task automatic t_setup();
        wr(5'h00, 32'h0);                       // disable boot bank
        wr(5'h04, 32'h1000_06BF);               // bank2 base, reserved bits set
        wr(5'h05, 32'hFFFF_0FFF);               // bank2 mask, reserved bits set
        wr(5'h0A, 32'h1000_01C1);               // bank5 wp, machine B
        wr(5'h0B, 32'hFFFF_8000);
        wr(5'h0C, 32'h2000_0101);               // bank6 wp
        wr(5'h0D, 32'hFFFF_8000);
        wr(5'h0E, 32'h3000_4001);               // bank7 type 100
        wr(5'h0F, 32'hFFFF_F000);
        wr(5'h08, 32'h4000_0000);               // bank4 invalid
        wr(5'h09, 32'hFFFF_8000);
        rd_check("R3 base2 reserved", 5'h04, 32'h1000_0681);
        rd_check("R3 opt2 reserved",  5'h05, 32'hFFFF_0000);
    endtask

    task automatic t_priority();
        access(1'b0, 1'b0, 32'h1000_0004, 3'b000);
        check("R7 low bank wins", {24'b0, chip_sel}, 32'h04);
        check("R8 hit_bank", {29'b0, hit_bank}, 32'd2);
        check("R8 port_size", {30'b0, port_size}, 32'h1);
        check("R8 parity_en", {31'b0, parity_en}, 32'h1);
        check("R8 machine", {30'b0, machine}, 32'h2);
        idle();
    endtask

    task automatic t_mask();
        access(1'b0, 1'b0, 32'h1000_8000, 3'b000);
        check("R4 masked bit ignored", {24'b0, chip_sel}, 32'h04);
        idle();
        access(1'b0, 1'b0, 32'h1001_0000, 3'b000);
        check("R4 compared bit differs", {31'b0, hit}, 32'h0);
        idle();
    endtask

    task automatic t_type();
        access(1'b0, 1'b0, 32'h3000_0010, 3'b000);
        check("R5 type mismatch", {31'b0, hit}, 32'h0);
        access(1'b0, 1'b0, 32'h3000_0010, 3'b100);
        check("R5 type match", {24'b0, chip_sel}, 32'h80);
        access(1'b0, 1'b1, 32'h3000_0010, 3'b000);
        check("R5 external forced", {24'b0, chip_sel}, 32'h80);
        idle();
    endtask

    task automatic t_invalid();
        access(1'b0, 1'b0, 32'h4000_0000, 3'b000);
        check("R6 invalid hit", {31'b0, hit}, 32'h0);
        check("R6 invalid cs", {24'b0, chip_sel}, 32'h0);
        check("R6 invalid ack", {31'b0, xfer_ack}, 32'h0);
        check("R8 no-hit fields", {27'b0, port_size, parity_en, machine}, 32'h0);
        idle();
    endtask

    task automatic t_wp();
        access(1'b0, 1'b0, 32'h2000_0000, 3'b000);
        check("R9 wp read cs", {24'b0, chip_sel}, 32'h40);
        check("R9 wp read ack", {31'b0, xfer_ack}, 32'h1);
        check("R9 read no err", {31'b0, wp_err}, 32'h0);
        access(1'b1, 1'b0, 32'h2000_0000, 3'b000);
        check("R9 wp write cs", {24'b0, chip_sel}, 32'h0);
        check("R9 wp write ack", {31'b0, xfer_ack}, 32'h0);
        idle();
        check("R9 err set", {31'b0, wp_err}, 32'h1);
        // bank2 loses valid: bank5 (wp) now wins the overlap
        wr(5'h04, 32'h1000_0680);
        access(1'b0, 1'b0, 32'h1000_0000, 3'b000);
        check("R7 next bank wins", {24'b0, chip_sel}, 32'h20);
        check("R8 machine B", {30'b0, machine}, 32'h3);
        idle();
    endtask

    task automatic t_sticky();
        repeat (3) idle();
        check("R10 held", {31'b0, wp_err}, 32'h1);
        wr(5'h10, 32'h0);
        check("R10 write 0 keeps", {31'b0, wp_err}, 32'h1);
        rd_check("R2 status read", 5'h10, 32'h1);
        wr(5'h10, 32'h1);
        check("R10 cleared", {31'b0, wp_err}, 32'h0);
        // clear and new violation in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_ext = 1'b0;
        acc_addr_hi = 17'h0_4000; acc_type = 3'b000;
        @(negedge clk);
        reg_we = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        #1 check("R10 set beats clear", {31'b0, wp_err}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_setup();
        t_priority();
        t_mask();
        t_type();
        t_invalid();
        t_wp();
        t_sticky();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule